// File: doc/BRIEF.md
# DMA Channel Interrupt Cause and Mask Controller

This block gathers the interrupt causes of one DMA channel into a 12-bit cause register, gates them with a mask register and drives a single level interrupt line toward the system interrupt controller. The channel engine reports events as single-cycle pulses: a 12-bit vector of general causes plus two descriptor-completion pulses, one for the source side and one for the destination side. Each completion pulse is also counted in its own 8-bit counter, which software drains by reading it. A counter that wraps raises its own error cause.

Software reaches the block through a simple 32-bit register port: one request per cycle (valid, write, byte address, write data). Read data comes back one cycle after the request with a valid flag. The mask cannot be written directly. Software unmasks causes through an enable register and masks them through a disable register, so a read-modify-write of the mask is never needed. Any access to an address that holds no register is flagged as a cause of its own.

The read-response path is a two-state machine. `PORT_IDLE` means no response is pending. `PORT_RDATA` means a read response is presented this cycle. A read request in either state moves the machine to `PORT_RDATA` (transition "read accept"). Any cycle without a read request returns it to `PORT_IDLE` (transition "response retire"). Write requests never leave `PORT_IDLE`.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Cause bit positions are fixed: 11 pause, 10 transfer done, 9 write-data error, 8 read-data error, 7 destination-descriptor read error, 6 source-descriptor read error, 5 destination count error, 4 source count error, 3 byte-count overflow, 2 destination descriptor done, 1 source descriptor done, 0 invalid access. A pulse on `evt_cause[i]` sets cause bit i at the next clock edge.
- R2: The cause register is at offset 0x00 and reads back in bits 11:0. Writing 1 to a bit clears it and writing 0 leaves it alone. Bits 31:12 of every read response are zero.
- R3: The mask register is at offset 0x04 and resets to 0xFFF. A write to offset 0x04 leaves the mask unchanged.
- R4: A write to the enable register (offset 0x08) clears every mask bit whose written bit is 1. A write to the disable register (offset 0x0C) sets every mask bit whose written bit is 1. Both registers read as zero.
- R5: `irq` is high exactly when some cause bit is set while its mask bit is clear. It follows the cause and mask registers with no further delay.
- R6: A `src_dscr_done` pulse increments the source counter (offset 0x10) and sets cause bit 1. A `dst_dscr_done` pulse increments the destination counter (offset 0x14) and sets cause bit 2.
- R7: An increment that wraps a counter from 255 to 0 also sets that side's count error cause: bit 4 for the source side, bit 5 for the destination side.
- R8: A read of a counter returns its value and clears it to zero. Writes to a counter are ignored.
- R9: Any access to an address other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 sets cause bit 0. Such a read returns zero and such a write changes no register.
- R10: When an event and a write-1-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R11: When a counter is read in the same cycle as its increment, the read returns the old value and the counter ends at 1, with no count error.
- R12: `rsp_valid` is high in the cycle after each read request and only then. `rsp_data` carries the register value as it stood before that request's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | Read data |
| evt_cause | input | CAUSE_W | Single-cycle event pulses, one per cause bit |
| src_dscr_done | input | 1 | Source descriptor completed with interrupt flag |
| dst_dscr_done | input | 1 | Destination descriptor completed with interrupt flag |
| irq | output | 1 | Level interrupt output |

## Verification
The embedded properties check several rules on every cycle. Set beats clear in the cause register. Enable and disable writes move exactly the addressed mask bits, and the mask is otherwise stable. Each counter steps by one, clears on read, or restarts at 1 when read and incremented together. A read response follows every read request, and its upper bits stay zero. Every unmapped access raises the invalid-access cause. Other behaviour is shown only by the bench's scenarios: that read data matches the register's previous value, the full 256-pulse wrap that raises a count error, the interrupt level against a reference model, and writes to read-only or unmapped addresses that leave state intact.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int CAUSE_W = 12;
    localparam int CNT_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    // cause bit positions (software decodes these)
    localparam int B_INVALID     = 0;
    localparam int B_SRC_DONE    = 1;
    localparam int B_DST_DONE    = 2;
    localparam int B_BYTE_OVF    = 3;
    localparam int B_SRC_CNT_ERR = 4;
    localparam int B_DST_CNT_ERR = 5;
    localparam int B_SRC_DSC_RD  = 6;
    localparam int B_DST_DSC_RD  = 7;
    localparam int B_RD_DATA     = 8;
    localparam int B_WR_DATA     = 9;
    localparam int B_XFER_DONE   = 10;
    localparam int B_PAUSE       = 11;

    // register byte offsets
    localparam logic [7:0] OFS_CAUSE = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_UNMSK = 8'h08;
    localparam logic [7:0] OFS_MSK   = 8'h0C;
    localparam logic [7:0] OFS_SCNT  = 8'h10;
    localparam logic [7:0] OFS_DCNT  = 8'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_MASK,
        SEL_UNMSK,
        SEL_MSK,
        SEL_SCNT,
        SEL_DCNT
    } reg_sel_e;

    typedef enum logic {
        PORT_IDLE,
        PORT_RDATA
    } port_state_e;

endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_ctrl_pkg::*;
#(
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_DATA_W  = DATA_W,
    parameter int P_CAUSE_W = CAUSE_W,
    parameter int P_CNT_W   = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [P_ADDR_W-1:0]  req_addr,
    input  logic [P_CAUSE_W-1:0] cause_q,
    input  logic [P_CAUSE_W-1:0] mask_q,
    input  logic [P_CNT_W-1:0]   scnt_q,
    input  logic [P_CNT_W-1:0]   dcnt_q,
    output reg_sel_e             sel,
    output logic                 bad_access,
    output logic                 rsp_valid,
    output logic [P_DATA_W-1:0]  rsp_data
);

    port_state_e state_q, state_d;
    logic [P_DATA_W-1:0] rd_mux;
    logic                rd_req;

    always_comb begin
        sel = SEL_NONE;
        if (req_addr == P_ADDR_W'(OFS_CAUSE))      sel = SEL_CAUSE;
        else if (req_addr == P_ADDR_W'(OFS_MASK))  sel = SEL_MASK;
        else if (req_addr == P_ADDR_W'(OFS_UNMSK)) sel = SEL_UNMSK;
        else if (req_addr == P_ADDR_W'(OFS_MSK))   sel = SEL_MSK;
        else if (req_addr == P_ADDR_W'(OFS_SCNT))  sel = SEL_SCNT;
        else if (req_addr == P_ADDR_W'(OFS_DCNT))  sel = SEL_DCNT;
    end

    assign bad_access = req_valid && (sel == SEL_NONE);
    assign rd_req     = req_valid && !req_write;

    always_comb begin
        unique case (sel)
            SEL_CAUSE: rd_mux = P_DATA_W'(cause_q);
            SEL_MASK:  rd_mux = P_DATA_W'(mask_q);
            SEL_SCNT:  rd_mux = P_DATA_W'(scnt_q);
            SEL_DCNT:  rd_mux = P_DATA_W'(dcnt_q);
            default:   rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // next state: read accept / response retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE:  state_d = rd_req ? PORT_RDATA : PORT_IDLE;
            PORT_RDATA: state_d = rd_req ? PORT_RDATA : PORT_IDLE;
            default:    state_d = PORT_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_data <= '0;
        else if (rd_req) rsp_data <= rd_mux;
    end

    always_comb rsp_valid = (state_q == PORT_RDATA);

    assert_rsp_follows_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    assert_no_rsp_without_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data[P_DATA_W-1:P_CAUSE_W] == '0));

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] cause_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_vec) | set_vec;
    end

    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));
    assert_clear_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unmask_stb,
    input  logic         mask_stb,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '1;
        else if (unmask_stb) mask_q <= mask_q & ~wbits;
        else if (mask_stb)   mask_q <= mask_q | wbits;
    end

    assert_unmask_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_stb |=> ((mask_q & $past(wbits)) == '0));
    assert_mask_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_stb && !unmask_stb) |=> ((mask_q & $past(wbits)) == $past(wbits)));
    assert_mask_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_stb && !unmask_stb) |=> $stable(mask_q));

endmodule

// File: rtl/irq_done_counter.sv
module irq_done_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);

    assign wrap = inc && !clr && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= W'(inc);
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt_q == '0));
    assert_read_and_inc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt_q == W'(1)));

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int ADDR_W  = irq_ctrl_pkg::ADDR_W,
    parameter int DATA_W  = irq_ctrl_pkg::DATA_W,
    parameter int CAUSE_W = irq_ctrl_pkg::CAUSE_W,
    parameter int CNT_W   = irq_ctrl_pkg::CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    input  logic [CAUSE_W-1:0] evt_cause,
    input  logic               src_dscr_done,
    input  logic               dst_dscr_done,
    output logic               irq
);

    localparam int N_SIDES = 2;

    reg_sel_e            sel;
    logic                bad_access;
    logic                wr_req, rd_req;
    logic [CAUSE_W-1:0]  cause_q, mask_q, set_vec, clr_vec, wbits;
    logic [N_SIDES-1:0]  cnt_inc, cnt_clr, cnt_wrap;
    logic [CNT_W-1:0]    cnt_val [N_SIDES];
    logic                unused_wdata_hi;

    assign wr_req = req_valid && req_write;
    assign rd_req = req_valid && !req_write;
    assign wbits  = req_wdata[CAUSE_W-1:0];
    assign unused_wdata_hi = ^req_wdata[DATA_W-1:CAUSE_W];

    irq_reg_port #(
        .P_ADDR_W (ADDR_W),
        .P_DATA_W (DATA_W),
        .P_CAUSE_W(CAUSE_W),
        .P_CNT_W  (CNT_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cause_q   (cause_q),
        .mask_q    (mask_q),
        .scnt_q    (cnt_val[0]),
        .dcnt_q    (cnt_val[1]),
        .sel       (sel),
        .bad_access(bad_access),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign cnt_inc = {dst_dscr_done, src_dscr_done};
    assign cnt_clr = {rd_req && (sel == SEL_DCNT), rd_req && (sel == SEL_SCNT)};

    generate
        for (genvar s = 0; s < N_SIDES; s++) begin : g_side
            irq_done_counter #(.W(CNT_W)) u_cnt (
                .clk  (clk),
                .rst_n(rst_n),
                .inc  (cnt_inc[s]),
                .clr  (cnt_clr[s]),
                .cnt_q(cnt_val[s]),
                .wrap (cnt_wrap[s])
            );
        end
    endgenerate

    always_comb begin
        set_vec                = evt_cause;
        set_vec[B_INVALID]     = evt_cause[B_INVALID]     | bad_access;
        set_vec[B_SRC_DONE]    = evt_cause[B_SRC_DONE]    | src_dscr_done;
        set_vec[B_DST_DONE]    = evt_cause[B_DST_DONE]    | dst_dscr_done;
        set_vec[B_SRC_CNT_ERR] = evt_cause[B_SRC_CNT_ERR] | cnt_wrap[0];
        set_vec[B_DST_CNT_ERR] = evt_cause[B_DST_CNT_ERR] | cnt_wrap[1];
    end

    assign clr_vec = (wr_req && sel == SEL_CAUSE) ? wbits : '0;

    irq_cause_reg #(.W(CAUSE_W)) u_cause (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .cause_q(cause_q)
    );

    irq_mask_reg #(.W(CAUSE_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .unmask_stb(wr_req && sel == SEL_UNMSK),
        .mask_stb  (wr_req && sel == SEL_MSK),
        .wbits     (wbits),
        .mask_q    (mask_q)
    );

    assign irq = |(cause_q & ~mask_q);

    assert_bad_access_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel == SEL_NONE) |=> cause_q[B_INVALID]);
    assert_src_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src_dscr_done |=> cause_q[B_SRC_DONE]);
    assert_dst_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_dscr_done |=> cause_q[B_DST_DONE]);
    assert_src_wrap_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_dscr_done && !cnt_clr[0] && cnt_val[0] == '1) |=> (cause_q[B_SRC_CNT_ERR] && cnt_val[0] == '0));
    assert_all_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

endmodule

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;

    localparam logic [7:0] A_CAUSE = 8'h00;
    localparam logic [7:0] A_MASK  = 8'h04;
    localparam logic [7:0] A_UNMSK = 8'h08;
    localparam logic [7:0] A_MSK   = 8'h0C;
    localparam logic [7:0] A_SCNT  = 8'h10;
    localparam logic [7:0] A_DCNT  = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [11:0] evt_cause = '0;
    logic        src_dscr_done = 1'b0, dst_dscr_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [11:0] m_cause, m_mask;
    logic [7:0]  m_scnt, m_dcnt;

    always #2 clk = ~clk;

    dma_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .evt_cause(evt_cause),
        .src_dscr_done(src_dscr_done), .dst_dscr_done(dst_dscr_done),
        .irq(irq)
    );

    function automatic logic mapped(input logic [7:0] a);
        return a == A_CAUSE || a == A_MASK || a == A_UNMSK ||
               a == A_MSK || a == A_SCNT || a == A_DCNT;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == A_CAUSE) return {20'h0, m_cause};
        if (a == A_MASK)  return {20'h0, m_mask};
        if (a == A_SCNT)  return {24'h0, m_scnt};
        if (a == A_DCNT)  return {24'h0, m_dcnt};
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        return |(m_cause & ~m_mask);
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One request/event cycle; called just after a falling edge.
    task automatic step(input string tag, input logic v, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic [11:0] ev, input logic sd, input logic dd);
        logic [31:0] erd;
        logic        rd, sclr, dclr, swrap, dwrap;
        logic [11:0] setv, clrv;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        evt_cause = ev; src_dscr_done = sd; dst_dscr_done = dd;
        rd    = v && !w;
        erd   = exp_read(a);
        sclr  = rd && a == A_SCNT;
        dclr  = rd && a == A_DCNT;
        swrap = sd && !sclr && m_scnt == 8'hFF;
        dwrap = dd && !dclr && m_dcnt == 8'hFF;
        m_scnt = sclr ? {7'h0, sd} : m_scnt + {7'h0, sd};
        m_dcnt = dclr ? {7'h0, dd} : m_dcnt + {7'h0, dd};
        setv = ev;
        setv[0] = setv[0] | (v && !mapped(a));
        setv[1] = setv[1] | sd;
        setv[2] = setv[2] | dd;
        setv[4] = setv[4] | swrap;
        setv[5] = setv[5] | dwrap;
        clrv = (v && w && a == A_CAUSE) ? d[11:0] : 12'h0;
        m_cause = (m_cause & ~clrv) | setv;
        if (v && w && a == A_UNMSK) m_mask = m_mask & ~d[11:0];
        if (v && w && a == A_MSK)   m_mask = m_mask | d[11:0];
        @(negedge clk);
        req_valid = 1'b0; evt_cause = '0; src_dscr_done = 1'b0; dst_dscr_done = 1'b0;
        check(tag, "rsp_valid", {31'h0, rsp_valid}, {31'h0, rd});
        if (rd) check(tag, "rsp_data", rsp_data, erd);
        check(tag, "irq", {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    task automatic rd_reg(input string tag, input logic [7:0] a);
        step(tag, 1'b1, 1'b0, a, 32'h0, 12'h0, 1'b0, 1'b0);
    endtask

    task automatic wr_reg(input string tag, input logic [7:0] a, input logic [31:0] d);
        step(tag, 1'b1, 1'b1, a, d, 12'h0, 1'b0, 1'b0);
    endtask

    task automatic idle_evt(input string tag, input logic [11:0] ev, input logic sd, input logic dd);
        step(tag, 1'b0, 1'b0, 8'h0, 32'h0, ev, sd, dd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        m_cause = '0; m_mask = 12'hFFF; m_scnt = '0; m_dcnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        check("R12", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R5", "reset irq", {31'h0, irq}, 32'h0);

        // R3: reset value and direct write has no effect
        rd_reg("R3", A_MASK);
        wr_reg("R3", A_MASK, 32'h0);
        rd_reg("R3", A_MASK);

        // R1/R5: event while masked, then unmask
        idle_evt("R1", 12'h400, 1'b0, 1'b0);
        rd_reg("R1", A_CAUSE);
        wr_reg("R4", A_UNMSK, 32'h0000_0400);
        rd_reg("R4", A_UNMSK);
        rd_reg("R4", A_MSK);
        rd_reg("R4", A_MASK);
        // R2: W1C and reserved bits
        wr_reg("R2", A_CAUSE, 32'hFFFF_F000);
        rd_reg("R2", A_CAUSE);
        wr_reg("R2", A_CAUSE, 32'h0000_0400);
        rd_reg("R2", A_CAUSE);
        wr_reg("R4", A_MSK, 32'h0000_0400);

        // R1: every cause bit individually
        wr_reg("R4", A_UNMSK, 32'h0000_0FFF);
        for (int b = 0; b < 12; b++) begin
            idle_evt("R1", 12'h1 << b, 1'b0, 1'b0);
            rd_reg("R1", A_CAUSE);
            wr_reg("R2", A_CAUSE, 32'h0000_0FFF);
        end

        // R10: set beats clear
        step("R10", 1'b1, 1'b1, A_CAUSE, 32'h0000_0801, 12'h800, 1'b0, 1'b0);
        rd_reg("R10", A_CAUSE);
        wr_reg("R2", A_CAUSE, 32'h0000_0FFF);

        // R6/R7: source counter wrap
        for (int k = 0; k < 255; k++) idle_evt("R6", 12'h0, 1'b1, 1'b0);
        rd_reg("R6", A_CAUSE);
        idle_evt("R7", 12'h0, 1'b1, 1'b0);
        rd_reg("R7", A_CAUSE);
        rd_reg("R8", A_SCNT);
        // R6/R7: destination counter wrap
        for (int k = 0; k < 256; k++) idle_evt("R7", 12'h0, 1'b0, 1'b1);
        rd_reg("R7", A_CAUSE);
        rd_reg("R8", A_DCNT);

        // R8: clear on read, writes ignored
        idle_evt("R6", 12'h0, 1'b1, 1'b1);
        idle_evt("R6", 12'h0, 1'b1, 1'b0);
        wr_reg("R8", A_SCNT, 32'h0000_0055);
        rd_reg("R8", A_SCNT);
        rd_reg("R8", A_SCNT);
        wr_reg("R8", A_DCNT, 32'h0000_00AA);
        rd_reg("R8", A_DCNT);
        rd_reg("R8", A_DCNT);

        // R11: read together with increment
        idle_evt("R11", 12'h0, 1'b1, 1'b0);
        idle_evt("R11", 12'h0, 1'b1, 1'b0);
        step("R11", 1'b1, 1'b0, A_SCNT, 32'h0, 12'h0, 1'b1, 1'b0);
        rd_reg("R11", A_SCNT);
        step("R11", 1'b1, 1'b0, A_DCNT, 32'h0, 12'h0, 1'b0, 1'b1);
        rd_reg("R11", A_DCNT);

        // R9: unmapped and unaligned accesses
        wr_reg("R2", A_CAUSE, 32'h0000_0FFF);
        rd_reg("R9", 8'h18);
        rd_reg("R9", A_CAUSE);
        wr_reg("R2", A_CAUSE, 32'h0000_0FFF);
        wr_reg("R9", 8'h02, 32'h0000_0FFF);
        wr_reg("R9", 8'hFC, 32'h0000_0FFF);
        rd_reg("R9", A_MASK);
        rd_reg("R9", A_CAUSE);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [11:0] ev;
            int pick;
            pick = $urandom_range(0, 7);
            case (pick)
                0: a = A_CAUSE;
                1: a = A_MASK;
                2: a = A_UNMSK;
                3: a = A_MSK;
                4: a = A_SCNT;
                5: a = A_DCNT;
                default: a = 8'($urandom);
            endcase
            ev = ($urandom_range(0, 5) == 0) ? 12'($urandom) : 12'h0;
            step("R5", ($urandom_range(0, 9) < 7), 1'($urandom), a, $urandom, ev,
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule